// File: doc/BRIEF.md
# Amplifier Channel Power Sequencer

This controller sequences the power state of one channel of a switching audio amplifier; a stereo part places one copy per channel, and each copy runs on its own. When the channel's active-low standby input is released, it enables the output bridge while holding the gain at mute for a timed interval. It then raises the gain code one step at a time until it reaches the level picked by the 2-bit gain select. When standby is asserted again, it lowers the gain step by step to mute. Only after that does it tri-state the bridge and return to off.

Two protection flags override this sequence. A short-circuit flag drops the channel at once into a latched fault state, with the bridge disabled. The channel leaves that state only after the standby input is taken low and then released. An over-temperature flag starts a normal ramp-down and keeps the channel off while it stays set. Once it clears, the channel wakes up again by itself. All time intervals are counted in clock ticks and set by parameters.

Top module: `chan_seq_top`

## Requirements
- R1: Reset, asynchronous and active low, puts the channel in state OFF (code 0) with gain step 0, output enable low and mute high. While the standby input is low the channel stays in OFF.
- R2: A release of standby (input high) passes through a two-flop synchronizer. The state becomes MUTE_DELAY (code 1) on the third rising edge after the change, with output enable high and gain step 0, and not earlier.
- R3: The channel stays in MUTE_DELAY for exactly MUTE_TICKS cycles and then enters RAMP_UP (code 2).
- R4: The target gain step is (sel+1)*STEPS_PER_LEVEL, so select 00, 01, 10 and 11 give the 6, 12, 18 and 24 dB levels: 1x, 2x, 3x and 4x STEPS_PER_LEVEL.
- R5: While ramping, the gain step changes by exactly one every RAMP_TICKS cycles and never by more than one per cycle. RAMP_UP turns into ACTIVE (code 3) one cycle after the gain reaches the target.
- R6: A change of gain select while ACTIVE ramps the gain toward the new target at the R5 rate in either direction. The gain never jumps to the new value.
- R7: Standby asserted while ACTIVE gives RAMP_DOWN (code 4) on the third edge. The gain then steps down to 0, output enable falls in the same cycle the gain reaches 0, and OFF follows one cycle later.
- R8: Standby asserted during MUTE_DELAY or RAMP_UP goes straight to RAMP_DOWN and ramps down from the current gain step.
- R9: A short-circuit flag in any operating state gives FAULT (code 5) on the second edge, with gain 0 and output enable low. FAULT persists after the flag clears and exits to OFF only when standby goes low. A later release starts a new wake-up.
- R10: An over-temperature flag gives RAMP_DOWN on the second edge. The channel is held in OFF while the flag stays set. When the flag clears, MUTE_DELAY follows on the second edge without any standby toggle.
- R11: The mute output is high exactly when the gain step is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| stbyN | input | 1 | Standby request, active low, asynchronous |
| gainSel | input | 2 | Gain select, bit 1 is the upper bit |
| shortFlt | input | 1 | Short-circuit fault flag |
| hotFlt | input | 1 | Over-temperature flag |
| gainStep | output | GAIN_W | Gain step code to the analog gain stage, 0 = mute |
| outEn | output | 1 | Bridge output enable (low = high impedance) |
| muteOn | output | 1 | High while gain step is 0 |
| chanState | output | 3 | State code: 0 OFF, 1 MUTE_DELAY, 2 RAMP_UP, 3 ACTIVE, 4 RAMP_DOWN, 5 FAULT |

## Verification
A standby edge takes effect on the third rising edge, because of the two synchronizer flops and the state register. A fault flag or gain select change takes effect on the second edge, because of the sample flop. Each later gain step lands RAMP_TICKS edges after the previous one. The bench uses MUTE_TICKS=4, RAMP_TICKS=2 and STEPS_PER_LEVEL=2. Every vector drives its inputs on a falling edge, waits an exact count of rising edges worked out from these latencies, and samples on the next falling edge, so that several vectors land on a cycle just before and just after a transition.

// File: rtl/chan_seq_pkg.sv
package chan_seq_pkg;
  typedef enum logic [2:0] {
    ST_OFF   = 3'd0,
    ST_MUTE  = 3'd1,
    ST_RISE  = 3'd2,
    ST_RUN   = 3'd3,
    ST_FALL  = 3'd4,
    ST_FAULT = 3'd5
  } chanStateT;

  typedef struct packed {
    logic stepUp;
    logic stepDn;
    logic clear;
  } gainCmdT;
endpackage

// File: rtl/chan_seq_gain.sv
module chan_seq_gain
  import chan_seq_pkg::*;
#(
  parameter int STEPS_PER_LEVEL = 4,
  parameter int GAIN_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        selR,
  input  gainCmdT           cmd,
  output logic [GAIN_W-1:0] gainStep,
  output logic              below,
  output logic              above,
  output logic              atZero
);
  logic [GAIN_W-1:0] target;

  assign target = GAIN_W'((int'(selR) + 1) * STEPS_PER_LEVEL);
  assign below  = gainStep < target;
  assign above  = gainStep > target;
  assign atZero = gainStep == '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             gainStep <= '0;
    else if (cmd.clear)    gainStep <= '0;
    else if (cmd.stepUp)   gainStep <= gainStep + GAIN_W'(1);
    else if (cmd.stepDn)   gainStep <= gainStep - GAIN_W'(1);
  end
endmodule

// File: rtl/chan_seq_ctrl.sv
module chan_seq_ctrl
  import chan_seq_pkg::*;
#(
  parameter int MUTE_TICKS = 1000,
  parameter int RAMP_TICKS = 100,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       stbyN,
  input  logic [1:0] gainSel,
  input  logic       shortFlt,
  input  logic       hotFlt,
  input  logic       below,
  input  logic       above,
  input  logic       atZero,
  output logic [1:0] selR,
  output gainCmdT    cmd,
  output logic       outEn,
  output chanStateT  state
);
  localparam int TMAX  = (MUTE_TICKS > RAMP_TICKS) ? MUTE_TICKS : RAMP_TICKS;
  localparam int TMR_W = $clog2(TMAX + 1);

  logic [SYNC_STAGES-1:0] syncQ;
  logic onReq, shortR, hotR, moving, tick, atTarget, hold;
  logic [TMR_W-1:0] timer;
  chanStateT nextState;

  assign onReq    = syncQ[SYNC_STAGES-1];
  assign atTarget = !below && !above;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ  <= '0;
      shortR <= 1'b0;
      hotR   <= 1'b0;
      selR   <= '0;
    end else begin
      syncQ  <= {syncQ[SYNC_STAGES-2:0], stbyN};
      shortR <= shortFlt;
      hotR   <= hotFlt;
      selR   <= gainSel;
    end
  end

  always_comb begin
    nextState = state;
    unique case (state)
      ST_OFF:   if (onReq && !hotR) nextState = ST_MUTE;
      ST_FAULT: if (!onReq) nextState = ST_OFF;
      ST_FALL: begin
        if (shortR)      nextState = ST_FAULT;
        else if (atZero) nextState = ST_OFF;
      end
      default: begin
        if (shortR)                 nextState = ST_FAULT;
        else if (!onReq || hotR)    nextState = ST_FALL;
        else if (state == ST_MUTE && timer == TMR_W'(MUTE_TICKS - 1)) nextState = ST_RISE;
        else if (state == ST_RISE && atTarget) nextState = ST_RUN;
      end
    endcase
  end

  assign moving = (state == ST_RISE) || (state == ST_FALL) || (state == ST_RUN && !atTarget);
  assign tick   = moving && (timer == TMR_W'(RAMP_TICKS - 1));
  assign hold   = nextState == state;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_OFF;
      timer <= '0;
    end else begin
      state <= nextState;
      if (!hold || (!moving && state != ST_MUTE)) timer <= '0;
      else if (tick)                              timer <= '0;
      else                                        timer <= timer + TMR_W'(1);
    end
  end

  always_comb begin
    cmd.clear  = (nextState == ST_FAULT) && (state != ST_FAULT);
    cmd.stepUp = tick && hold && (state == ST_RISE || state == ST_RUN) && below;
    cmd.stepDn = tick && hold && ((state == ST_FALL && !atZero) ||
                                  ((state == ST_RISE || state == ST_RUN) && above));
  end

  assign outEn = (state == ST_MUTE) || (state == ST_RISE) || (state == ST_RUN) ||
                 (state == ST_FALL && !atZero);
endmodule

// File: rtl/chan_seq_top.sv
module chan_seq_top
  import chan_seq_pkg::*;
#(
  parameter int MUTE_TICKS = 1000,
  parameter int RAMP_TICKS = 100,
  parameter int STEPS_PER_LEVEL = 4,
  parameter int GAIN_W = $clog2(4 * STEPS_PER_LEVEL + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              stbyN,
  input  logic [1:0]        gainSel,
  input  logic              shortFlt,
  input  logic              hotFlt,
  output logic [GAIN_W-1:0] gainStep,
  output logic              outEn,
  output logic              muteOn,
  output logic [2:0]        chanState
);
  gainCmdT   cmd;
  chanStateT state;
  logic [1:0] selR;
  logic below, above, atZero;

  chan_seq_ctrl #(.MUTE_TICKS(MUTE_TICKS), .RAMP_TICKS(RAMP_TICKS), .SYNC_STAGES(2)) uCtrl (
    .clk(clk), .rstN(rstN), .stbyN(stbyN), .gainSel(gainSel), .shortFlt(shortFlt),
    .hotFlt(hotFlt), .below(below), .above(above), .atZero(atZero), .selR(selR),
    .cmd(cmd), .outEn(outEn), .state(state)
  );

  chan_seq_gain #(.STEPS_PER_LEVEL(STEPS_PER_LEVEL), .GAIN_W(GAIN_W)) uGain (
    .clk(clk), .rstN(rstN), .selR(selR), .cmd(cmd), .gainStep(gainStep),
    .below(below), .above(above), .atZero(atZero)
  );

  assign muteOn    = atZero;
  assign chanState = state;
endmodule

// File: rtl/chan_seq_chk.sv
module chan_seq_chk #(
  parameter int GAIN_W = 5,
  parameter int MAX_STEP = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic [GAIN_W-1:0] gainStep,
  input logic              outEn,
  input logic              muteOn,
  input logic [2:0]        chanState
);
  // R1, R9: bridge is off in OFF and FAULT
  a_r1_off_no_drive: assert property (@(posedge clk) disable iff (!rstN)
    (chanState == 3'd0 || chanState == 3'd5) |-> (!outEn && gainStep == '0));

  // R5: at most one step per cycle, except the clear on fault entry
  a_r5_single_step: assert property (@(posedge clk) disable iff (!rstN)
    (chanState != 3'd5) |-> (gainStep == $past(gainStep) ||
                             gainStep == $past(gainStep) + GAIN_W'(1) ||
                             gainStep + GAIN_W'(1) == $past(gainStep)));

  // R4: gain never exceeds the top level
  a_r4_gain_bound: assert property (@(posedge clk) disable iff (!rstN)
    int'(gainStep) <= MAX_STEP);

  // R9: fault exits only to OFF
  a_r9_fault_exit: assert property (@(posedge clk) disable iff (!rstN)
    (chanState == 3'd5) |=> (chanState == 3'd5 || chanState == 3'd0));

  // R5: ACTIVE is reached only through RAMP_UP
  a_r5_active_entry: assert property (@(posedge clk) disable iff (!rstN)
    (chanState != 3'd3 && chanState != 3'd2) |=> (chanState != 3'd3));

  // R7: OFF after a ramp-down only with the gain at mute
  a_r7_off_after_mute: assert property (@(posedge clk) disable iff (!rstN)
    (chanState == 3'd4) |=> (chanState != 3'd0 || $past(gainStep) == '0));

  // R11: mute flag mirrors a zero gain step
  a_r11_mute_flag: assert property (@(posedge clk) disable iff (!rstN)
    muteOn == (gainStep == '0));
endmodule

bind chan_seq_top chan_seq_chk #(.GAIN_W(GAIN_W), .MAX_STEP(4 * STEPS_PER_LEVEL)) uChk (
  .clk(clk), .rstN(rstN), .gainStep(gainStep), .outEn(outEn),
  .muteOn(muteOn), .chanState(chanState)
);

// File: tb/sim_chan_seq_top.sv
`timescale 1ns/1ps
module sim_chan_seq_top;
  localparam int GW = 4;

  logic clk = 1'b0;
  logic rstN, stbyN, shortFlt, hotFlt;
  logic [1:0] gainSel;
  logic [GW-1:0] gainStep;
  logic outEn, muteOn;
  logic [2:0] chanState;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  chan_seq_top #(.MUTE_TICKS(4), .RAMP_TICKS(2), .STEPS_PER_LEVEL(2), .GAIN_W(GW)) u0 (
    .clk(clk), .rstN(rstN), .stbyN(stbyN), .gainSel(gainSel), .shortFlt(shortFlt),
    .hotFlt(hotFlt), .gainStep(gainStep), .outEn(outEn), .muteOn(muteOn),
    .chanState(chanState)
  );

  typedef struct packed {
    logic       sb;
    logic [1:0] sel;
    logic       sh;
    logic       hot;
    logic [7:0] cyc;
    logic [2:0] st;
    logic [3:0] gain;
    logic       en;
    logic [3:0] req;
  } vecT;

  localparam int NV = 35;
  localparam vecT VEC [NV] = '{
    '{1'b0, 2'd0, 1'b0, 1'b0, 8'd10, 3'd0, 4'd0, 1'b0, 4'd1},  // R1 held off
    '{1'b1, 2'd0, 1'b0, 1'b0, 8'd2,  3'd0, 4'd0, 1'b0, 4'd2},  // R2 not yet
    '{1'b1, 2'd0, 1'b0, 1'b0, 8'd1,  3'd1, 4'd0, 1'b1, 4'd2},  // R2 third edge
    '{1'b1, 2'd0, 1'b0, 1'b0, 8'd3,  3'd1, 4'd0, 1'b1, 4'd3},  // R3 still muted
    '{1'b1, 2'd0, 1'b0, 1'b0, 8'd1,  3'd2, 4'd0, 1'b1, 4'd3},  // R3 ramp begins
    '{1'b1, 2'd0, 1'b0, 1'b0, 8'd2,  3'd2, 4'd1, 1'b1, 4'd5},  // R5
    '{1'b1, 2'd0, 1'b0, 1'b0, 8'd2,  3'd2, 4'd2, 1'b1, 4'd4},  // R4 level 00
    '{1'b1, 2'd0, 1'b0, 1'b0, 8'd1,  3'd3, 4'd2, 1'b1, 4'd5},  // R5 active
    '{1'b1, 2'd3, 1'b0, 1'b0, 8'd3,  3'd3, 4'd3, 1'b1, 4'd6},  // R6 one step
    '{1'b1, 2'd3, 1'b0, 1'b0, 8'd11, 3'd3, 4'd8, 1'b1, 4'd4},  // R4 level 11
    '{1'b1, 2'd0, 1'b0, 1'b0, 8'd14, 3'd3, 4'd2, 1'b1, 4'd6},  // R6 down
    '{1'b0, 2'd0, 1'b0, 1'b0, 8'd3,  3'd4, 4'd2, 1'b1, 4'd7},  // R7
    '{1'b0, 2'd0, 1'b0, 1'b0, 8'd2,  3'd4, 4'd1, 1'b1, 4'd7},  // R7
    '{1'b0, 2'd0, 1'b0, 1'b0, 8'd2,  3'd4, 4'd0, 1'b0, 4'd7},  // R7 enable drops
    '{1'b0, 2'd0, 1'b0, 1'b0, 8'd1,  3'd0, 4'd0, 1'b0, 4'd7},  // R7 off
    '{1'b1, 2'd1, 1'b0, 1'b0, 8'd3,  3'd1, 4'd0, 1'b1, 4'd2},  // R2
    '{1'b0, 2'd1, 1'b0, 1'b0, 8'd3,  3'd4, 4'd0, 1'b0, 4'd8},  // R8 abort mute
    '{1'b0, 2'd1, 1'b0, 1'b0, 8'd1,  3'd0, 4'd0, 1'b0, 4'd8},  // R8
    '{1'b1, 2'd3, 1'b0, 1'b0, 8'd7,  3'd2, 4'd0, 1'b1, 4'd3},  // R3
    '{1'b1, 2'd3, 1'b0, 1'b0, 8'd4,  3'd2, 4'd2, 1'b1, 4'd5},  // R5
    '{1'b0, 2'd3, 1'b0, 1'b0, 8'd3,  3'd4, 4'd3, 1'b1, 4'd8},  // R8 abort ramp
    '{1'b0, 2'd3, 1'b0, 1'b0, 8'd6,  3'd4, 4'd0, 1'b0, 4'd8},  // R8
    '{1'b0, 2'd3, 1'b0, 1'b0, 8'd1,  3'd0, 4'd0, 1'b0, 4'd8},  // R8
    '{1'b1, 2'd0, 1'b0, 1'b0, 8'd12, 3'd3, 4'd2, 1'b1, 4'd5},  // R5
    '{1'b1, 2'd0, 1'b1, 1'b0, 8'd2,  3'd5, 4'd0, 1'b0, 4'd9},  // R9 fault
    '{1'b1, 2'd0, 1'b0, 1'b0, 8'd10, 3'd5, 4'd0, 1'b0, 4'd9},  // R9 latched
    '{1'b0, 2'd0, 1'b0, 1'b0, 8'd3,  3'd0, 4'd0, 1'b0, 4'd9},  // R9 cleared
    '{1'b1, 2'd0, 1'b0, 1'b0, 8'd3,  3'd1, 4'd0, 1'b1, 4'd9},  // R9 rewake
    '{1'b1, 2'd0, 1'b0, 1'b0, 8'd9,  3'd3, 4'd2, 1'b1, 4'd10}, // R10 setup
    '{1'b1, 2'd0, 1'b0, 1'b1, 8'd2,  3'd4, 4'd2, 1'b1, 4'd10}, // R10
    '{1'b1, 2'd0, 1'b0, 1'b1, 8'd2,  3'd4, 4'd1, 1'b1, 4'd10}, // R10
    '{1'b1, 2'd0, 1'b0, 1'b1, 8'd2,  3'd4, 4'd0, 1'b0, 4'd10}, // R10
    '{1'b1, 2'd0, 1'b0, 1'b1, 8'd1,  3'd0, 4'd0, 1'b0, 4'd10}, // R10
    '{1'b1, 2'd0, 1'b0, 1'b1, 8'd5,  3'd0, 4'd0, 1'b0, 4'd10}, // R10 held
    '{1'b1, 2'd0, 1'b0, 1'b0, 8'd2,  3'd1, 4'd0, 1'b1, 4'd10}  // R10 auto return
  };

  task automatic check(input int req, input logic [2:0] st, input logic [3:0] g, input logic en);
    checks++;
    // R11: mute must equal (gain == 0)
    if (chanState !== st || gainStep !== g || outEn !== en || muteOn !== (g == 4'd0)) begin
      fails++;
      $display("FAIL R%0d: state=%0d gain=%0d en=%b mute=%b expected state=%0d gain=%0d en=%b mute=%b",
               req, chanState, gainStep, outEn, muteOn, st, g, en, (g == 4'd0));
    end
  endtask

  initial begin
    rstN = 1'b0; stbyN = 1'b0; gainSel = 2'd0; shortFlt = 1'b0; hotFlt = 1'b0;
    repeat (3) @(negedge clk);
    check(1, 3'd0, 4'd0, 1'b0);  // R1 during reset
    rstN = 1'b1;
    for (int i = 0; i < NV; i++) begin
      stbyN = VEC[i].sb; gainSel = VEC[i].sel; shortFlt = VEC[i].sh; hotFlt = VEC[i].hot;
      repeat (int'(VEC[i].cyc)) @(posedge clk);
      @(negedge clk);
      check(int'(VEC[i].req), VEC[i].st, VEC[i].gain, VEC[i].en);
    end
    // R4: level 10 gives step 6
    hotFlt = 1'b0; stbyN = 1'b1; gainSel = 2'd2;
    repeat (20) @(posedge clk); @(negedge clk);
    check(4, 3'd3, 4'd6, 1'b1);
    // R6, R4: level 01 gives step 4, reached by two down-steps
    gainSel = 2'd1;
    repeat (3) @(posedge clk); @(negedge clk);
    check(6, 3'd3, 4'd5, 1'b1);
    repeat (3) @(posedge clk); @(negedge clk);
    check(4, 3'd3, 4'd4, 1'b1);
    // R1: reset in mid-operation clears at once
    rstN = 1'b0; #1;
    check(1, 3'd0, 4'd0, 1'b0);
    @(negedge clk); rstN = 1'b1; stbyN = 1'b0;
    repeat (4) @(negedge clk);
    check(1, 3'd0, 4'd0, 1'b0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule